// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns three digitized Hall-sensor levels into six gate enables for a three-phase half-bridge. Each leg has an upper and a lower switch. For every valid Hall code one phase is driven high, one is driven low and one floats. The direction select reverses the commutation sequence. A PWM on/off level chops only the upper switch of the high phase. During the off part of each PWM period, the lower switch of that same leg conducts as a synchronous rectifier, so current does not flow through the body diode.

A stop request overrides commutation. The brake-mode select then picks one of two stop behaviours: coasting with every switch open, or braking by shorting the windings through all lower switches. A protection trip forces every upper switch off. Each leg applies a fixed dead time, in clock cycles, between turning one of its switches off and turning a switch on. All control pins are plain levels. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `bldc_commutator`

## Requirements
- R1: With `fwd_i`=1, `stop_i`=0, `trip_i`=0 and `pwm_on_i`=1, the Hall code {`hall_i[2]`,`hall_i[1]`,`hall_i[0]`} selects the phases as follows (phase A is bit 0, B is bit 1, C is bit 2 of both gate buses; high phase / low phase): 001 gives A/B, 011 gives A/C, 010 gives B/C, 110 gives B/A, 100 gives C/A, 101 gives C/B. The high phase has its upper switch on, the low phase has its lower switch on, and the third phase has both switches off.
- R2: With `fwd_i`=0, each code drives the same two phases as in R1, but the roles of high and low are swapped.
- R3: PWM chopping acts only on the upper switch of the high phase. That switch is on when `pwm_on_i`=1, and the low phase keeps its lower switch on whatever `pwm_on_i` is.
- R4: When `pwm_on_i`=0 while running, the high phase turns its lower switch on instead of its upper switch (synchronous rectification).
- R5: While running, Hall codes 000 and 111 open all six switches.
- R6: With `stop_i`=1 and `coast_i`=1, all six switches are off, whatever the Hall code is.
- R7: With `stop_i`=1 and `coast_i`=0, all three lower switches are on and all upper switches are off.
- R8: While `trip_i`=1, every upper switch is off. The leg of the high phase is fully open, and the lower switch of the low phase stays on.
- R9: A leg never has its upper and lower switches on at the same time.
- R10: After any switch of a leg turns off, no switch of that leg turns on until the leg has been fully off for `DEAD_CYC` clock cycles. When a request is waiting, it is granted on exactly the `DEAD_CYC`-th edge after the turn-off edge.
- R11: A switch that is no longer requested turns off on the first clock edge after the request changes. A switch requested in a leg whose dead time has already elapsed turns on at that same first edge.
- R12: While `rst_n` is low, all gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Digitized Hall levels, bit 0 = phase A |
| fwd_i | input | 1 | 1 = forward sequence, 0 = reversed |
| stop_i | input | 1 | 1 = stop, 0 = run |
| coast_i | input | 1 | Stop behaviour: 1 = coast, 0 = short-circuit brake |
| pwm_on_i | input | 1 | PWM level for the high-phase upper switch |
| trip_i | input | 1 | Protection trip, forces upper switches off |
| gate_hi_o | output | 3 | Upper switch enables, bit 0 = phase A |
| gate_lo_o | output | 3 | Lower switch enables, bit 0 = phase A |

## Verification
There is one register stage between the inputs and the gates. A switch that must open does so at the first edge after the input change. A switch whose leg has already waited out its dead time closes at that same edge. A switch that must wait appears on the `DEAD_CYC`-th edge after its leg opened. The steady-state tests change inputs on a falling edge and then sample `DEAD_CYC`+3 edges later, so every pending dead time has expired. The timing tests sample one time unit after each rising edge and count edges from the change, so they check the turn-off edge and the exact grant edge separately.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int NPH = 3;
  typedef logic [1:0] phase_idx_t;
  typedef enum logic [1:0] {
    PH_FLOAT = 2'd0,
    PH_HIGH  = 2'd1,
    PH_LOW   = 2'd2
  } phase_drv_e;
endpackage

// File: rtl/hall_sector_decode.sv
module hall_sector_decode
  import bldc_pkg::*;
(
  input  logic                   [2:0]   hall_i,
  input  logic                           fwd_i,
  output phase_drv_e             [NPH-1:0] drv_o
);
  logic       valid;
  phase_idx_t src_idx, snk_idx, hi_idx, lo_idx;

  // Forward sequence: source (high) and sink (low) phase per code
  always_comb begin
    valid   = 1'b1;
    src_idx = 2'd0;
    snk_idx = 2'd0;
    unique case (hall_i)
      3'b001:  begin src_idx = 2'd0; snk_idx = 2'd1; end
      3'b011:  begin src_idx = 2'd0; snk_idx = 2'd2; end
      3'b010:  begin src_idx = 2'd1; snk_idx = 2'd2; end
      3'b110:  begin src_idx = 2'd1; snk_idx = 2'd0; end
      3'b100:  begin src_idx = 2'd2; snk_idx = 2'd0; end
      3'b101:  begin src_idx = 2'd2; snk_idx = 2'd1; end
      default: valid = 1'b0;
    endcase
  end

  assign hi_idx = fwd_i ? src_idx : snk_idx;
  assign lo_idx = fwd_i ? snk_idx : src_idx;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign drv_o[p] = !valid                  ? PH_FLOAT :
                      (hi_idx == 2'(p))       ? PH_HIGH  :
                      (lo_idx == 2'(p))       ? PH_LOW   : PH_FLOAT;
  end
endmodule

// File: rtl/drive_request.sv
module drive_request
  import bldc_pkg::*;
(
  input  phase_drv_e [NPH-1:0] drv_i,
  input  logic                 stop_i,
  input  logic                 coast_i,
  input  logic                 pwm_on_i,
  input  logic                 trip_i,
  output logic       [NPH-1:0] want_hi_o,
  output logic       [NPH-1:0] want_lo_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_req
    always_comb begin
      want_hi_o[p] = 1'b0;
      want_lo_o[p] = 1'b0;
      if (stop_i) begin
        want_lo_o[p] = ~coast_i;
      end else begin
        unique case (drv_i[p])
          PH_HIGH: begin
            want_hi_o[p] = pwm_on_i & ~trip_i;
            want_lo_o[p] = ~pwm_on_i & ~trip_i;
          end
          PH_LOW:  want_lo_o[p] = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gate_leg_deadtime.sv
module gate_leg_deadtime #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi_i,
  input  logic want_lo_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  logic [CW-1:0] wait_q;
  logic          hi_q, lo_q;
  logic          drop;

  assign drop = (hi_q & ~want_hi_i) | (lo_q & ~want_lo_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      wait_q <= '0;
    end else if (drop) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      wait_q <= CW'(DEAD_CYC - 1);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end else begin
      hi_q <= want_hi_i;
      lo_q <= want_lo_i;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       fwd_i,
  input  logic       stop_i,
  input  logic       coast_i,
  input  logic       pwm_on_i,
  input  logic       trip_i,
  output logic [2:0] gate_hi_o,
  output logic [2:0] gate_lo_o
);
  phase_drv_e [NPH-1:0] drv;
  logic       [NPH-1:0] want_hi, want_lo;

  hall_sector_decode u_dec (
    .hall_i (hall_i),
    .fwd_i  (fwd_i),
    .drv_o  (drv)
  );

  drive_request u_req (
    .drv_i     (drv),
    .stop_i    (stop_i),
    .coast_i   (coast_i),
    .pwm_on_i  (pwm_on_i),
    .trip_i    (trip_i),
    .want_hi_o (want_hi),
    .want_lo_o (want_lo)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    gate_leg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_hi_i (want_hi[p]),
      .want_lo_i (want_lo[p]),
      .hi_o      (gate_hi_o[p]),
      .lo_o      (gate_lo_o[p])
    );
  end
endmodule

// File: rtl/bldc_commutator_checker.sv
module bldc_commutator_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall_i,
  input logic       stop_i,
  input logic       coast_i,
  input logic       trip_i,
  input logic [2:0] gate_hi_o,
  input logic [2:0] gate_lo_o
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_OPEN: assert ((gate_hi_o | gate_lo_o) == 3'b000); // R12
    end
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_o & gate_lo_o) == 3'b000); // R9

  AST_TRIP_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> gate_hi_o == 3'b000); // R8

  AST_COAST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && coast_i) |=> (gate_hi_o | gate_lo_o) == 3'b000); // R6

  AST_BRAKE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !coast_i) |=> gate_hi_o == 3'b000); // R7

  AST_BAD_HALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && (hall_i == 3'b000 || hall_i == 3'b111))
      |=> (gate_hi_o | gate_lo_o) == 3'b000); // R5

  for (genvar g = 0; g < 3; g++) begin : g_dead
    logic [CW-1:0] off_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         off_run <= CW'(DEAD_CYC);
      else if (gate_hi_o[g] || gate_lo_o[g]) off_run <= '0;
      else if (off_run < CW'(DEAD_CYC))   off_run <= off_run + 1'b1;
    end
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hi_o[g]) || $rose(gate_lo_o[g])) |-> off_run >= CW'(DEAD_CYC)); // R10
  end
endmodule

bind bldc_commutator bldc_commutator_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hall_i    (hall_i),
  .stop_i    (stop_i),
  .coast_i   (coast_i),
  .trip_i    (trip_i),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o)
);

// File: tb/bldc_commutator_test.sv
`timescale 1ns/1ps
module bldc_commutator_test;
  localparam int DC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b001;
  logic       fwd = 1'b1, stop = 1'b1, coast = 1'b1, pwm = 1'b1, trip = 1'b0;
  logic [2:0] ghi, glo;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bldc_commutator #(.DEAD_CYC(DC)) uut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .fwd_i(fwd), .stop_i(stop),
    .coast_i(coast), .pwm_on_i(pwm), .trip_i(trip),
    .gate_hi_o(ghi), .gate_lo_o(glo)
  );

  // Expected {hi,lo} while running, from the R1/R2 phase table
  function automatic logic [5:0] exp_run(logic [2:0] h, logic f, logic p, logic t);
    int hp, lp;
    logic [2:0] eh, el;
    case (h)
      3'b001: begin hp = 0; lp = 1; end
      3'b011: begin hp = 0; lp = 2; end
      3'b010: begin hp = 1; lp = 2; end
      3'b110: begin hp = 1; lp = 0; end
      3'b100: begin hp = 2; lp = 0; end
      3'b101: begin hp = 2; lp = 1; end
      default: return 6'b0;
    endcase
    if (!f) begin int tmp = hp; hp = lp; lp = tmp; end
    eh = '0; el = '0;
    el[lp] = 1'b1;
    if (!t) begin
      if (p) eh[hp] = 1'b1;
      else   el[hp] = 1'b1;
    end
    return {eh, el};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hi/lo actual %b_%b expected %b_%b", req, act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic apply(logic [2:0] h, logic f, logic s, logic c, logic p, logic t);
    @(negedge clk);
    hall = h; fwd = f; stop = s; coast = c; pwm = p; trip = t;
  endtask

  task automatic settle();
    repeat (DC + 3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R12 reset", {ghi, glo}, 6'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset held", {ghi, glo}, 6'b0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_table(logic f, string req);
    logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    for (int i = 0; i < 6; i++) begin
      apply(seq[i], f, 1'b0, 1'b1, 1'b1, 1'b0);
      settle();
      check(req, {ghi, glo}, exp_run(seq[i], f, 1'b1, 1'b0));
    end
  endtask

  task automatic t_sync_rect();
    for (int f = 0; f < 2; f++) begin
      apply(3'b110, f[0], 1'b0, 1'b1, 1'b0, 1'b0);
      settle();
      check("R4 sync rect", {ghi, glo}, exp_run(3'b110, f[0], 1'b0, 1'b0));
      apply(3'b110, f[0], 1'b0, 1'b1, 1'b1, 1'b0);
      settle();
      check("R3 pwm on upper", {ghi, glo}, exp_run(3'b110, f[0], 1'b1, 1'b0));
    end
  endtask

  task automatic t_invalid();
    apply(3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    settle();
    check("R5 code 000", {ghi, glo}, 6'b0);
    apply(3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    settle();
    check("R5 code 111", {ghi, glo}, 6'b0);
  endtask

  task automatic t_stop();
    apply(3'b010, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    settle();
    check("R6 coast", {ghi, glo}, 6'b0);
    apply(3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    check("R7 brake", {ghi, glo}, {3'b000, 3'b111});
    apply(3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    settle();
    check("R7 brake bad hall", {ghi, glo}, {3'b000, 3'b111});
  endtask

  task automatic t_trip();
    apply(3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    settle();
    check("R8 trip", {ghi, glo}, {3'b000, 3'b010});
    apply(3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    settle();
    check("R8 trip rev", {ghi, glo}, exp_run(3'b100, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_dead();
    apply(3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    settle();
    check("R10 start", {ghi, glo}, {3'b001, 3'b010});
    apply(3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k <= DC; k++) begin
      @(posedge clk);
      #1;
      if (k == 0) check("R11 upper off first edge", {ghi, glo}, {3'b000, 3'b010});
      check("R10 lower grant edge", {ghi, glo}, {3'b000, (k == DC) ? 3'b011 : 3'b010});
    end
    apply(3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k <= DC; k++) begin
      @(posedge clk);
      #1;
      check("R10 upper grant edge", {ghi, glo}, {(k == DC) ? 3'b001 : 3'b000, 3'b010});
    end
  endtask

  task automatic t_latency();
    apply(3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    settle();
    apply(3'b011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    @(posedge clk);
    #1;
    check("R11 turn-on first edge", {ghi, glo}, {3'b001, 3'b100});
  endtask

  initial begin
    t_reset();
    t_table(1'b1, "R1 forward");
    t_table(1'b0, "R2 reverse");
    t_sync_rect();
    t_invalid();
    t_stop();
    t_trip();
    t_dead();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule